// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block makes every control decision of a five-stage in-order pipeline. The stages are fetch (F), decode (D), execute (X), memory (M) and writeback (W). It does not hold the pipeline registers. It looks at the valid bit of each stage, the register numbers read in decode, the destination registers and write enables further down, a load flag in execute, branch and jump outcomes, and the ready state of each stage's port. From these it works out, in the same cycle, which stages stall and which are squashed. It also works out the operand forwarding choice for each decode source and the valid bit that each stage passes to the stage behind it.

Stalls come from two places. One is a load whose result a decode instruction needs: the value exists only once the load reaches M, so decode and fetch wait one cycle. The other is a port that is not ready. A stage also waits whenever the stage downstream of it waits. A taken conditional branch is resolved in X and kills the instructions in D and F. A jump is resolved in D and kills only the instruction in F. All other read-after-write cases are forwarded, so they cost no cycles.

A 12-bit status word packs the per-stage flags. It is registered once, for trace capture. Every other output is combinational.

Top module: `hazard_ctrl`

## Requirements
- R1: A load-use hazard stalls D and F in the same cycle. The condition is: D is valid, a source it uses matches the nonzero destination of a valid, writing load in X. Once the load has moved to M, the same operand is forwarded from M with no stall.
- R2: A valid taken branch in X, when X is not stalled, raises squash_d and squash_f. A not-taken branch raises neither signal and stalls nothing.
- R3: A valid jump in D, when D is not stalled and no branch squash is active, raises squash_f only. A jump in a stalled D squashes nothing.
- R4: Each decode source has a forwarding select: 0 = register file, 1 = X, 2 = M, 3 = W. A producer stage counts only if it is valid, writing, and targets the same register. Priority is X over M over W. Register 0 always selects 0 and never causes a stall.
- R5: A valid stage stalls when the next stage downstream stalls. An invalid stage never stalls, so a bubble absorbs back-pressure.
- R6: A valid stage whose port ready input is low stalls. This applies to F, D, M and W. The stall spreads to every valid upstream stage.
- R7: When a stage is squashed, its stall output is 0 in the same cycle.
- R8: adv_val_s = val_s AND NOT stall_s AND NOT squash_s, for s in F, D, X, M. X and M cannot be squashed.
- R9: One cycle after each edge, dbg_word holds {val_f, squash_f, stall_f, val_d, squash_d, stall_d, val_x, stall_x, val_m, stall_m, val_w, stall_w}, bit 11 first, as sampled at that edge. Reset clears it to 0.
- R10: A non-load producer in X, M or W that matches a decode source causes no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the status register |
| val_f | input | 1 | F holds an instruction |
| val_d | input | 1 | D holds an instruction |
| val_x | input | 1 | X holds an instruction |
| val_m | input | 1 | M holds an instruction |
| val_w | input | 1 | W holds an instruction |
| rs1_d | input | REG_AW | First source register in D |
| rs2_d | input | REG_AW | Second source register in D |
| rs1_use_d | input | 1 | D reads the first source |
| rs2_use_d | input | 1 | D reads the second source |
| rd_x | input | REG_AW | Destination in X |
| wen_x | input | 1 | X writes a register |
| is_load_x | input | 1 | X is a load |
| rd_m | input | REG_AW | Destination in M |
| wen_m | input | 1 | M writes a register |
| rd_w | input | REG_AW | Destination in W |
| wen_w | input | 1 | W writes a register |
| br_taken_x | input | 1 | Branch in X is taken |
| jump_d | input | 1 | D holds a jump |
| port_rdy_f | input | 1 | Instruction port can proceed for F |
| port_rdy_d | input | 1 | Source port can proceed for D |
| port_rdy_m | input | 1 | Data port can proceed for M |
| port_rdy_w | input | 1 | Sink port can proceed for W |
| stall_f | output | 1 | F holds |
| stall_d | output | 1 | D holds |
| stall_x | output | 1 | X holds |
| stall_m | output | 1 | M holds |
| stall_w | output | 1 | W holds |
| squash_f | output | 1 | F instruction is killed |
| squash_d | output | 1 | D instruction is killed |
| byp_sel1_d | output | 2 | Forwarding select, first source |
| byp_sel2_d | output | 2 | Forwarding select, second source |
| adv_val_f | output | 1 | Valid passed from F into D |
| adv_val_d | output | 1 | Valid passed from D into X |
| adv_val_x | output | 1 | Valid passed from X into M |
| adv_val_m | output | 1 | Valid passed from M into W |
| dbg_word | output | 12 | Registered status word |

## Verification
Stall, squash, forwarding and advance outputs depend only on the current inputs. They are due in the cycle the inputs are applied. The bench drives each input set on a falling edge and samples a quarter period later, before the next rising edge. The status word is due one rising edge later. Each scoreboard entry therefore expects the packing of the previous entry's inputs and expected flags. The load-use case is checked as two consecutive entries: the load first sits in X, then moves to M. This confirms the stall lasts exactly one cycle.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    BYP_RF = 2'd0,
    BYP_X  = 2'd1,
    BYP_M  = 2'd2,
    BYP_W  = 2'd3
  } byp_sel_e;

  localparam int unsigned NUM_SRC = 2;
  localparam int unsigned DBG_W   = 12;
endpackage

// File: rtl/hz_operand.sv
module hz_operand
  import hz_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] rs,
  input  logic              use_rs,
  input  logic              val_d,
  input  logic              val_x,
  input  logic [REG_AW-1:0] rd_x,
  input  logic              wen_x,
  input  logic              is_load_x,
  input  logic              val_m,
  input  logic [REG_AW-1:0] rd_m,
  input  logic              wen_m,
  input  logic              val_w,
  input  logic [REG_AW-1:0] rd_w,
  input  logic              wen_w,
  output byp_sel_e          sel,
  output logic              load_dep
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic nz, hit_x, hit_m, hit_w;

  // a producer counts only when valid, writing and targeting this source
  always_comb begin
    nz    = (rs != ZERO_REG);
    hit_x = nz && val_x && wen_x && (rd_x == rs);
    hit_m = nz && val_m && wen_m && (rd_m == rs);
    hit_w = nz && val_w && wen_w && (rd_w == rs);
  end

  // youngest producer wins
  always_comb begin
    if (hit_x)      sel = BYP_X;
    else if (hit_m) sel = BYP_M;
    else if (hit_w) sel = BYP_W;
    else            sel = BYP_RF;
  end

  // a load value in X does not exist yet, so decode must wait
  assign load_dep = val_d && use_rs && hit_x && is_load_x;
endmodule

// File: rtl/hz_flow.sv
module hz_flow (
  input  logic val_f,
  input  logic val_d,
  input  logic val_x,
  input  logic val_m,
  input  logic val_w,
  input  logic load_use,
  input  logic br_taken_x,
  input  logic jump_d,
  input  logic rdy_f,
  input  logic rdy_d,
  input  logic rdy_m,
  input  logic rdy_w,
  output logic st_f,
  output logic st_d,
  output logic st_x,
  output logic st_m,
  output logic st_w,
  output logic sq_f,
  output logic sq_d,
  output logic adv_f,
  output logic adv_d,
  output logic adv_x,
  output logic adv_m
);
  logic st_d_raw, jmp_go;

  // back-pressure runs from the tail toward the head
  always_comb begin
    st_w = val_w && !rdy_w;
    st_m = val_m && (!rdy_m || st_w);
    st_x = val_x && st_m;
  end

  // branch resolves in X and kills D and F
  assign sq_d = val_x && br_taken_x && !st_x;

  // decode holds for load-use, its own port, or a held X
  assign st_d_raw = val_d && (load_use || !rdy_d || st_x);
  assign st_d     = st_d_raw && !sq_d;

  // jump resolves in D and kills only F
  assign jmp_go = val_d && jump_d && !st_d_raw && !sq_d;
  assign sq_f   = sq_d || jmp_go;
  assign st_f   = val_f && (!rdy_f || st_d) && !sq_f;

  always_comb begin
    adv_f = val_f && !st_f && !sq_f;
    adv_d = val_d && !st_d && !sq_d;
    adv_x = val_x && !st_x;
    adv_m = val_m && !st_m;
  end
endmodule

// File: rtl/hz_dbg_reg.sv
module hz_dbg_reg #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hz_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              val_f,
  input  logic              val_d,
  input  logic              val_x,
  input  logic              val_m,
  input  logic              val_w,
  input  logic [REG_AW-1:0] rs1_d,
  input  logic [REG_AW-1:0] rs2_d,
  input  logic              rs1_use_d,
  input  logic              rs2_use_d,
  input  logic [REG_AW-1:0] rd_x,
  input  logic              wen_x,
  input  logic              is_load_x,
  input  logic [REG_AW-1:0] rd_m,
  input  logic              wen_m,
  input  logic [REG_AW-1:0] rd_w,
  input  logic              wen_w,
  input  logic              br_taken_x,
  input  logic              jump_d,
  input  logic              port_rdy_f,
  input  logic              port_rdy_d,
  input  logic              port_rdy_m,
  input  logic              port_rdy_w,
  output logic              stall_f,
  output logic              stall_d,
  output logic              stall_x,
  output logic              stall_m,
  output logic              stall_w,
  output logic              squash_f,
  output logic              squash_d,
  output logic [1:0]        byp_sel1_d,
  output logic [1:0]        byp_sel2_d,
  output logic              adv_val_f,
  output logic              adv_val_d,
  output logic              adv_val_x,
  output logic              adv_val_m,
  output logic [11:0]       dbg_word
);
  logic [REG_AW-1:0] rs_arr  [NUM_SRC];
  logic              use_arr [NUM_SRC];
  byp_sel_e          sel_arr [NUM_SRC];
  logic [NUM_SRC-1:0] dep_vec;
  logic              load_use;
  logic [DBG_W-1:0]  dbg_next;

  assign rs_arr[0]  = rs1_d;
  assign rs_arr[1]  = rs2_d;
  assign use_arr[0] = rs1_use_d;
  assign use_arr[1] = rs2_use_d;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    hz_operand #(.REG_AW(REG_AW)) u_op (
      .rs        (rs_arr[i]),
      .use_rs    (use_arr[i]),
      .val_d     (val_d),
      .val_x     (val_x),
      .rd_x      (rd_x),
      .wen_x     (wen_x),
      .is_load_x (is_load_x),
      .val_m     (val_m),
      .rd_m      (rd_m),
      .wen_m     (wen_m),
      .val_w     (val_w),
      .rd_w      (rd_w),
      .wen_w     (wen_w),
      .sel       (sel_arr[i]),
      .load_dep  (dep_vec[i])
    );
  end

  assign load_use   = |dep_vec;
  assign byp_sel1_d = sel_arr[0];
  assign byp_sel2_d = sel_arr[1];

  hz_flow u_flow (
    .val_f      (val_f),
    .val_d      (val_d),
    .val_x      (val_x),
    .val_m      (val_m),
    .val_w      (val_w),
    .load_use   (load_use),
    .br_taken_x (br_taken_x),
    .jump_d     (jump_d),
    .rdy_f      (port_rdy_f),
    .rdy_d      (port_rdy_d),
    .rdy_m      (port_rdy_m),
    .rdy_w      (port_rdy_w),
    .st_f       (stall_f),
    .st_d       (stall_d),
    .st_x       (stall_x),
    .st_m       (stall_m),
    .st_w       (stall_w),
    .sq_f       (squash_f),
    .sq_d       (squash_d),
    .adv_f      (adv_val_f),
    .adv_d      (adv_val_d),
    .adv_x      (adv_val_x),
    .adv_m      (adv_val_m)
  );

  // status word: trace tools decode this bit order
  assign dbg_next = {val_f, squash_f, stall_f,
                     val_d, squash_d, stall_d,
                     val_x, stall_x,
                     val_m, stall_m,
                     val_w, stall_w};

  hz_dbg_reg #(.W(DBG_W)) u_dbg (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (dbg_next),
    .q     (dbg_word)
  );
endmodule

// File: rtl/hazard_ctrl_chk.sv
module hazard_ctrl_chk #(
  parameter int unsigned REG_AW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              val_d,
  input logic              val_x,
  input logic [REG_AW-1:0] rs1_d,
  input logic [REG_AW-1:0] rs2_d,
  input logic              rs1_use_d,
  input logic              rs2_use_d,
  input logic [REG_AW-1:0] rd_x,
  input logic              wen_x,
  input logic              is_load_x,
  input logic              br_taken_x,
  input logic              jump_d,
  input logic              stall_f,
  input logic              stall_d,
  input logic              stall_x,
  input logic              stall_m,
  input logic              stall_w,
  input logic              squash_f,
  input logic              squash_d,
  input logic [1:0]        byp_sel1_d,
  input logic              adv_val_f,
  input logic [11:0]       dbg_word
);
  // R1
  load_use_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (val_d && val_x && is_load_x && wen_x && (rd_x != '0) &&
     ((rs1_use_d && rs1_d == rd_x) || (rs2_use_d && rs2_d == rd_x)))
    |-> (stall_d && stall_f));

  // R2
  branch_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (val_x && br_taken_x && !stall_x) |-> (squash_d && squash_f));

  // R3
  jump_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (val_d && jump_d && !stall_d && !(val_x && br_taken_x)) |-> (squash_f && !squash_d));

  // R4
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs1_d == '0) |-> (byp_sel1_d == 2'd0));

  // R5
  chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_m && val_x) |-> stall_x);

  // R7
  squash_over_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(squash_d && stall_d) && !(squash_f && stall_f));

  // R8
  adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_f || squash_f) |-> !adv_val_f);

  // R9
  dbg_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_w |=> dbg_word[0]);

  // R9
  dbg_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    squash_f |=> dbg_word[10]);
endmodule

bind hazard_ctrl hazard_ctrl_chk #(.REG_AW(REG_AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .val_d      (val_d),
  .val_x      (val_x),
  .rs1_d      (rs1_d),
  .rs2_d      (rs2_d),
  .rs1_use_d  (rs1_use_d),
  .rs2_use_d  (rs2_use_d),
  .rd_x       (rd_x),
  .wen_x      (wen_x),
  .is_load_x  (is_load_x),
  .br_taken_x (br_taken_x),
  .jump_d     (jump_d),
  .stall_f    (stall_f),
  .stall_d    (stall_d),
  .stall_x    (stall_x),
  .stall_m    (stall_m),
  .stall_w    (stall_w),
  .squash_f   (squash_f),
  .squash_d   (squash_d),
  .byp_sel1_d (byp_sel1_d),
  .adv_val_f  (adv_val_f),
  .dbg_word   (dbg_word)
);

// File: tb/tb_hazard_ctrl.sv
module tb_hazard_ctrl;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [4:0] val;   // f d x m w
    logic [4:0] rs1, rs2;
    logic       u1, u2;
    logic [4:0] rdx; logic wx, ldx;
    logic [4:0] rdm; logic wm;
    logic [4:0] rdw; logic ww;
    logic       br, jmp;
    logic [3:0] rdy;   // f d m w
  } stim_t;

  typedef struct packed {
    logic [4:0] st;    // f d x m w
    logic       sqf, sqd;
    logic [1:0] s1, s2;
    logic [3:0] vo;    // f d x m
  } exp_t;

  typedef struct {
    exp_t        e;
    logic [11:0] dbg;
    string       tag;
  } item_t;

  logic clk = 0, rst_n = 0;
  stim_t s;
  item_t q[$];
  event sample_ev;
  int n_cmp = 0, n_bad = 0;
  logic [11:0] prev_dbg = '0;

  logic stall_f, stall_d, stall_x, stall_m, stall_w, squash_f, squash_d;
  logic [1:0] byp_sel1_d, byp_sel2_d;
  logic adv_val_f, adv_val_d, adv_val_x, adv_val_m;
  logic [11:0] dbg_word;

  always #(CLK_PERIOD/2) clk = ~clk;

  hazard_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .val_f(s.val[4]), .val_d(s.val[3]), .val_x(s.val[2]), .val_m(s.val[1]), .val_w(s.val[0]),
    .rs1_d(s.rs1), .rs2_d(s.rs2), .rs1_use_d(s.u1), .rs2_use_d(s.u2),
    .rd_x(s.rdx), .wen_x(s.wx), .is_load_x(s.ldx),
    .rd_m(s.rdm), .wen_m(s.wm), .rd_w(s.rdw), .wen_w(s.ww),
    .br_taken_x(s.br), .jump_d(s.jmp),
    .port_rdy_f(s.rdy[3]), .port_rdy_d(s.rdy[2]), .port_rdy_m(s.rdy[1]), .port_rdy_w(s.rdy[0]),
    .stall_f(stall_f), .stall_d(stall_d), .stall_x(stall_x), .stall_m(stall_m), .stall_w(stall_w),
    .squash_f(squash_f), .squash_d(squash_d),
    .byp_sel1_d(byp_sel1_d), .byp_sel2_d(byp_sel2_d),
    .adv_val_f(adv_val_f), .adv_val_d(adv_val_d), .adv_val_x(adv_val_x), .adv_val_m(adv_val_m),
    .dbg_word(dbg_word)
  );

  task automatic cmp(string tag, string fld, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, fld, act, exp);
    end
  endtask

  function automatic stim_t base();
    stim_t b = '0;
    b.val = 5'b11111;
    b.rdy = 4'b1111;
    return b;
  endfunction

  function automatic exp_t idle();
    exp_t e = '0;
    e.vo = 4'b1111;
    return e;
  endfunction

  // R9 packing, bit 11 first
  function automatic logic [11:0] pack(stim_t v, exp_t e);
    return {v.val[4], e.sqf, e.st[4], v.val[3], e.sqd, e.st[3],
            v.val[2], e.st[2], v.val[1], e.st[1], v.val[0], e.st[0]};
  endfunction

  task automatic step(stim_t v, exp_t e, string tag);
    item_t it;
    @(negedge clk);
    s = v;
    it.e = e; it.dbg = prev_dbg; it.tag = tag;
    q.push_back(it);
    prev_dbg = pack(v, e);
    #(CLK_PERIOD/4);
    -> sample_ev;
  endtask

  // monitor
  initial begin
    forever begin
      item_t it;
      @(sample_ev);
      it = q.pop_front();
      cmp(it.tag, "stall", {11'd0, stall_f, stall_d, stall_x, stall_m, stall_w}, {11'd0, it.e.st});
      cmp(it.tag, "squash", {14'd0, squash_f, squash_d}, {14'd0, it.e.sqf, it.e.sqd});
      cmp(it.tag, "sel1", {14'd0, byp_sel1_d}, {14'd0, it.e.s1});
      cmp(it.tag, "sel2", {14'd0, byp_sel2_d}, {14'd0, it.e.s2});
      cmp(it.tag, "adv", {12'd0, adv_val_f, adv_val_d, adv_val_x, adv_val_m}, {12'd0, it.e.vo});
      cmp({it.tag, " R9"}, "dbg", {4'd0, dbg_word}, {4'd0, it.dbg});
    end
  end

  initial begin
    #(CLK_PERIOD * 4000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    stim_t v; exp_t e;
    s = '0;
    repeat (2) @(negedge clk);
    cmp("R9 reset", "dbg", {4'd0, dbg_word}, 16'd0);
    rst_n = 1;
    @(negedge clk);

    // R8 idle flow
    step(base(), idle(), "R8 idle");

    // R10 R4 forward from X
    v = base(); v.rs1 = 3; v.u1 = 1; v.rdx = 3; v.wx = 1;
    e = idle(); e.s1 = 2'd1;
    step(v, e, "R10 R4 fwd X");

    // R4 priority X over M over W
    v = base(); v.rs1 = 3; v.rs2 = 5; v.u1 = 1; v.u2 = 1;
    v.rdx = 5; v.wx = 1; v.rdm = 3; v.wm = 1; v.rdw = 3; v.ww = 1;
    e = idle(); e.s1 = 2'd2; e.s2 = 2'd1;
    step(v, e, "R4 prio M/X");

    v = base(); v.rs1 = 3; v.rs2 = 9; v.rdw = 3; v.ww = 1;
    e = idle(); e.s1 = 2'd3;
    step(v, e, "R4 fwd W");

    // R4 x0 never forwarded or stalled
    v = base(); v.u1 = 1; v.u2 = 1; v.wx = 1; v.ldx = 1; v.wm = 1; v.ww = 1;
    step(v, idle(), "R4 x0");

    // R1 load-use then forward from M
    v = base(); v.rs1 = 6; v.u1 = 1; v.rdx = 6; v.wx = 1; v.ldx = 1;
    e = idle(); e.st = 5'b11000; e.s1 = 2'd1; e.vo = 4'b0011;
    step(v, e, "R1 load-use");
    v = base(); v.val = 5'b11011; v.rs1 = 6; v.u1 = 1; v.rdm = 6; v.wm = 1;
    e = idle(); e.s1 = 2'd2; e.vo = 4'b1101;
    step(v, e, "R1 one cycle");

    // R10 load match on unused source
    v = base(); v.rs1 = 6; v.rdx = 6; v.wx = 1; v.ldx = 1;
    e = idle(); e.s1 = 2'd1;
    step(v, e, "R10 unused src");

    // R2 taken and not taken
    v = base(); v.br = 1;
    e = idle(); e.sqf = 1; e.sqd = 1; e.vo = 4'b0011;
    step(v, e, "R2 taken");
    step(base(), idle(), "R2 not taken");

    // R3 jump kills F only
    v = base(); v.jmp = 1;
    e = idle(); e.sqf = 1; e.vo = 4'b0111;
    step(v, e, "R3 jump");
    v = base(); v.jmp = 1; v.br = 1;
    e = idle(); e.sqf = 1; e.sqd = 1; e.vo = 4'b0011;
    step(v, e, "R3 R2 jump+branch");
    v = base(); v.jmp = 1; v.rs1 = 6; v.u1 = 1; v.rdx = 6; v.wx = 1; v.ldx = 1;
    e = idle(); e.st = 5'b11000; e.s1 = 2'd1; e.vo = 4'b0011;
    step(v, e, "R3 jump held");

    // R6 R5 ports
    v = base(); v.rdy = 4'b1110;
    e = idle(); e.st = 5'b11111; e.vo = 4'b0000;
    step(v, e, "R6 W port");
    v = base(); v.rdy = 4'b1101;
    e = idle(); e.st = 5'b11110; e.vo = 4'b0000;
    step(v, e, "R6 M port");
    v = base(); v.rdy = 4'b0111;
    e = idle(); e.st = 5'b10000; e.vo = 4'b0111;
    step(v, e, "R6 F port");
    v = base(); v.val = 5'b11011; v.rdy = 4'b1101;
    e = idle(); e.st = 5'b00010; e.vo = 4'b1100;
    step(v, e, "R5 bubble absorbs");

    // R7 squash beats stall
    v = base(); v.br = 1; v.rdy = 4'b1011;
    e = idle(); e.sqf = 1; e.sqd = 1; e.vo = 4'b0011;
    step(v, e, "R7 squash over port");
    v = base(); v.br = 1; v.rdy = 4'b1101;
    e = idle(); e.st = 5'b11110; e.vo = 4'b0000;
    step(v, e, "R2 R5 branch held");

    step(base(), idle(), "R9 tail");
    #(CLK_PERIOD);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule